// File: doc/BRIEF.md
# Translation Entry Maintenance Unit

This block holds a small table of virtual-to-physical translation entries and performs the four maintenance operations that system software uses on such a table. Each entry holds a page-size mask, a high word and two low words. The high word carries the virtual page-pair number, an address-space identifier and a global flag. The two low words describe the even page and the odd page of the pair. The caller presents an operation code and a set of staging-register values and pulses a start strobe. The block is busy for one cycle. It then raises a one-cycle done pulse, and at that point the updated index and staging values are available on its outputs.

The four operations are probe, read-by-index, write-by-index and write-to-random-slot. The block also holds a wired count, which reserves the lowest slots, and a random slot index. The random index is derived from a free-running counter and never falls below the wired count. In the table, the global flag is held once per entry, in the high word. It appears in both low staging words when an entry is read. It is stored as set only when both low staging words carry it.

Top module: `tlbm_unit`

## Requirements
- R1: While reset is applied and after it is released, `op_busy`, `op_done`, `idx_out`, `mask_out`, `hi_out`, `lo0_out`, `lo1_out` and `wired_out` are all zero.
- R2: A strobe on `op_go` while `op_busy` is low is accepted. `op_busy` is then high for exactly one cycle, followed by `op_done` high for exactly one cycle with the results on the outputs. A strobe seen while `op_busy` is high is ignored. Opcodes: 0 probe, 1 read-by-index, 2 write-by-index, 3 write-random.
- R3: A probe with no matching entry returns `idx_out` = 0xFFFFFFFF80000000.
- R4: A probe compares high-word bits 31:13 (page-pair number) for equality. It also requires that the entry's global flag is set, or that its identifier (bits 7:0) equals bits 7:0 of `stg_hi`. When several entries match, the highest-numbered one is returned in `idx_out`.
- R5: A read with an in-range index returns the stored mask, high word and both low words. When the entry is global, it sets bit 0 of both `lo0_out` and `lo1_out` and clears bit 12 of `hi_out`. A read-by-index returns `idx_out` equal to `stg_index`.
- R6: A write stores the mask as `stg_mask` ANDed with 0x01FFE000 (bits 24:13). It stores the high word as `stg_hi` with the stored mask bits cleared and bit 12 cleared.
- R7: A write marks the entry global only when bit 0 is set in both `stg_lo0` and `stg_lo1`. Both stored low words have bit 0 cleared.
- R8: A read or write whose `stg_index` is 32 or more has no effect: the staging outputs equal the staging inputs and no entry changes.
- R9: A configuration write with `cfg_sel`=0 loads `wired_out` with `cfg_wdata` masked to 5 bits. A configuration write with `cfg_sel`=1 targets the random index, is ignored and changes nothing.
- R10: `random_out` equals `wired_out` + (c mod (32 − `wired_out`)), where c is an 8-bit counter that advances every clock. Write-random stores into the slot shown on `random_out` in the cycle the strobe is accepted, so that slot is never below the wired count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_go | input | 1 | Operation start strobe |
| op_code | input | 2 | Operation: 0 probe, 1 read, 2 write-index, 3 write-random |
| stg_index | input | 64 | Index staging register value |
| stg_mask | input | 32 | Page-mask staging register value |
| stg_hi | input | 32 | High-word staging value |
| stg_lo0 | input | 32 | Even-page low-word staging value |
| stg_lo1 | input | 32 | Odd-page low-word staging value |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects wired count, 1 selects random index |
| cfg_wdata | input | 32 | Configuration write data |
| op_busy | output | 1 | Operation accepted, executing |
| op_done | output | 1 | One-cycle completion pulse; outputs valid |
| idx_out | output | 64 | Updated index staging value |
| mask_out | output | 32 | Updated mask staging value |
| hi_out | output | 32 | Updated high-word staging value |
| lo0_out | output | 32 | Updated even low-word staging value |
| lo1_out | output | 32 | Updated odd low-word staging value |
| wired_out | output | 5 | Wired count |
| random_out | output | 5 | Current random slot index |

## Verification
The assertions watch, on every cycle, the busy-then-done pulse sequence and the range of probe results. They also watch the split of the global flag on reads, the clearing of bit 0 in stored low words, the priority encoder's choice of the highest hit, the masking of wired writes, the immunity of the wired count to random-index writes, and the lower bound of the random index. Only the bench scenarios can show that stored fields round-trip through write and read in every slot. The same holds for three other properties: probe results against a full table with overlapping matches, out-of-range operations leaving the table untouched, and the random index following the modulo sequence for several wired counts.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRIDX = 2'd2,
    OP_WRRND = 2'd3
  } tlbm_op_e;

  localparam int WORDW    = 32;
  localparam int IDXREGW  = 64;
  localparam int PAGE_LSB = 13;
  localparam int MASKW    = 12;
  localparam int ASIDW    = 8;
  localparam int HI_G_BIT = 12;
  localparam int LO_G_BIT = 0;
  localparam int VPNW     = WORDW - PAGE_LSB;

  localparam logic [IDXREGW-1:0] PROBE_MISS = {{(IDXREGW-31){1'b1}}, 31'b0};

endpackage

// File: rtl/tlbm_rand.sv
module tlbm_rand #(
  parameter int NENT = 32,
  parameter int CNTW = 8,
  parameter int IDXW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [31:0]     cfg_wdata,
  output logic [IDXW-1:0] wired,
  output logic [IDXW-1:0] rnd
);

  logic [IDXW-1:0] wired_q, wired_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] span;
  logic [CNTW-1:0] rnd_wide;
  logic            wired_en;

  assign wired_en = cfg_we && !cfg_sel;

  always_comb begin
    wired_d = wired_q;
    if (wired_en) wired_d = cfg_wdata[IDXW-1:0];
    cnt_d = cnt_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wired_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (wired_en) wired_q <= wired_d;
      cnt_q <= cnt_d;
    end
  end

  assign span     = CNTW'(NENT) - CNTW'(wired_q);
  assign rnd_wide = CNTW'(wired_q) + (cnt_q % span);
  assign rnd      = rnd_wide[IDXW-1:0];
  assign wired    = wired_q;

  // R9: wired load keeps only the index-width bits
  a_r9_wired_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (32'(wired_q) == ($past(cfg_wdata) & 32'((1 << IDXW) - 1))));

  // R9: a write aimed at the random index leaves the wired count alone
  a_r9_random_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> $stable(wired_q));

  // R10: random slot stays inside [wired, NENT)
  a_r10_random_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd >= wired_q) && (rnd_wide < CNTW'(NENT)));

endmodule

// File: rtl/tlbm_prio.sv
module tlbm_prio #(
  parameter int NENT = 32,
  parameter int IDXW = $clog2(NENT)
) (
  input  logic [NENT-1:0] hit,
  output logic            any,
  output logic [IDXW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NENT; i++) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    if (any) begin
      a_r4_hit_valid: assert (hit[idx]);
      a_r4_highest_wins: assert ((hit >> idx) == NENT'(1));
    end
  end

endmodule

// File: rtl/tlbm_store.sv
module tlbm_store
  import tlbm_pkg::*;
#(
  parameter int NENT = 32,
  parameter int IDXW = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDXW-1:0]  widx,
  input  logic [MASKW-1:0] wmask,
  input  logic [WORDW-1:0] whi,
  input  logic [WORDW-1:0] wlo0,
  input  logic [WORDW-1:0] wlo1,
  input  logic [IDXW-1:0]  ridx,
  output logic [WORDW-1:0] rmask,
  output logic [WORDW-1:0] rhi,
  output logic [WORDW-1:0] rlo0,
  output logic [WORDW-1:0] rlo1,
  input  logic [VPNW-1:0]  p_vpn,
  input  logic [ASIDW-1:0] p_asid,
  output logic [NENT-1:0]  hit
);

  logic [MASKW-1:0] ent_mask_q [NENT];
  logic [WORDW-1:0] ent_hi_q   [NENT];
  logic [WORDW-1:0] ent_lo0_q  [NENT];
  logic [WORDW-1:0] ent_lo1_q  [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        ent_mask_q[i] <= '0;
        ent_hi_q[i]   <= '0;
        ent_lo0_q[i]  <= '0;
        ent_lo1_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (we && (widx == IDXW'(i))) begin
          ent_mask_q[i] <= wmask;
          ent_hi_q[i]   <= whi;
          ent_lo0_q[i]  <= wlo0;
          ent_lo1_q[i]  <= wlo1;
        end
      end
    end
  end

  assign rmask = {{(WORDW-PAGE_LSB-MASKW){1'b0}}, ent_mask_q[ridx], {PAGE_LSB{1'b0}}};
  assign rhi   = ent_hi_q[ridx];
  assign rlo0  = ent_lo0_q[ridx];
  assign rlo1  = ent_lo1_q[ridx];

  for (genvar g = 0; g < NENT; g++) begin : g_match
    assign hit[g] = (ent_hi_q[g][WORDW-1:PAGE_LSB] == p_vpn) &&
                    (ent_hi_q[g][HI_G_BIT] || (ent_hi_q[g][ASIDW-1:0] == p_asid));
  end

  // R7: stored low words never keep the global bit
  a_r7_lo_g_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (!ent_lo0_q[$past(widx)][LO_G_BIT] && !ent_lo1_q[$past(widx)][LO_G_BIT]));

endmodule

// File: rtl/tlbm_unit.sv
module tlbm_unit
  import tlbm_pkg::*;
#(
  parameter int NENT = 32,
  parameter int CNTW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_go,
  input  logic [1:0]              op_code,
  input  logic [63:0]             stg_index,
  input  logic [31:0]             stg_mask,
  input  logic [31:0]             stg_hi,
  input  logic [31:0]             stg_lo0,
  input  logic [31:0]             stg_lo1,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [31:0]             cfg_wdata,
  output logic                    op_busy,
  output logic                    op_done,
  output logic [63:0]             idx_out,
  output logic [31:0]             mask_out,
  output logic [31:0]             hi_out,
  output logic [31:0]             lo0_out,
  output logic [31:0]             lo1_out,
  output logic [$clog2(NENT)-1:0] wired_out,
  output logic [$clog2(NENT)-1:0] random_out
);

  localparam int IDXW = $clog2(NENT);
  localparam logic [WORDW-1:0] HI_G = WORDW'(1) << HI_G_BIT;
  localparam logic [WORDW-1:0] LO_G = WORDW'(1) << LO_G_BIT;

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // capture stage
  logic               busy_q, busy_d, done_q, done_d;
  logic               cap_en, exe_en;
  tlbm_op_e           op_q, op_d;
  logic [IDXREGW-1:0] sidx_q;
  logic [WORDW-1:0]   smask_q, shi_q, slo0_q, slo1_q;
  logic [IDXW-1:0]    tgt_q, tgt_d;
  logic               tgt_ok_q, tgt_ok_d;
  logic [IDXW-1:0]    rnd_idx;

  assign cap_en = op_go && !busy_q;
  assign exe_en = busy_q;

  always_comb begin
    busy_d   = cap_en;
    done_d   = busy_q;
    op_d     = tlbm_op_e'(op_code);
    if (op_d == OP_WRRND) begin
      tgt_d    = rnd_idx;
      tgt_ok_d = 1'b1;
    end else begin
      tgt_d    = stg_index[IDXW-1:0];
      tgt_ok_d = (stg_index < IDXREGW'(NENT));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_PROBE;
      sidx_q   <= '0;
      smask_q  <= '0;
      shi_q    <= '0;
      slo0_q   <= '0;
      slo1_q   <= '0;
      tgt_q    <= '0;
      tgt_ok_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cap_en) begin
        op_q     <= op_d;
        sidx_q   <= stg_index;
        smask_q  <= stg_mask;
        shi_q    <= stg_hi;
        slo0_q   <= stg_lo0;
        slo1_q   <= stg_lo1;
        tgt_q    <= tgt_d;
        tgt_ok_q <= tgt_ok_d;
      end
    end
  end

  // random / wired registers
  tlbm_rand #(.NENT(NENT), .CNTW(CNTW), .IDXW(IDXW)) u_rand (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .wired     (wired_out),
    .rnd       (rnd_idx)
  );
  assign random_out = rnd_idx;

  // write shaping: fold global flag, clear masked page bits
  logic [MASKW-1:0] wm_fld;
  logic [WORDW-1:0] wm_word, w_hi, w_lo0, w_lo1;
  logic             w_glob, st_we;

  always_comb begin
    wm_fld  = smask_q[PAGE_LSB +: MASKW];
    wm_word = WORDW'(wm_fld) << PAGE_LSB;
    w_glob  = slo0_q[LO_G_BIT] && slo1_q[LO_G_BIT];
    w_hi    = (shi_q & ~wm_word & ~HI_G) | (w_glob ? HI_G : '0);
    w_lo0   = slo0_q & ~LO_G;
    w_lo1   = slo1_q & ~LO_G;
    st_we   = exe_en && tgt_ok_q && ((op_q == OP_WRIDX) || (op_q == OP_WRRND));
  end

  logic [WORDW-1:0] r_mask, r_hi, r_lo0, r_lo1;
  logic [NENT-1:0]  hit_vec;
  logic             p_any;
  logic [IDXW-1:0]  p_idx;

  tlbm_store #(.NENT(NENT), .IDXW(IDXW)) u_store (
    .clk    (clk),
    .rst_n  (rst_ni),
    .we     (st_we),
    .widx   (tgt_q),
    .wmask  (wm_fld),
    .whi    (w_hi),
    .wlo0   (w_lo0),
    .wlo1   (w_lo1),
    .ridx   (tgt_q),
    .rmask  (r_mask),
    .rhi    (r_hi),
    .rlo0   (r_lo0),
    .rlo1   (r_lo1),
    .p_vpn  (shi_q[WORDW-1:PAGE_LSB]),
    .p_asid (shi_q[ASIDW-1:0]),
    .hit    (hit_vec)
  );

  tlbm_prio #(.NENT(NENT), .IDXW(IDXW)) u_prio (
    .hit (hit_vec),
    .any (p_any),
    .idx (p_idx)
  );

  // execute stage results
  logic [IDXREGW-1:0] idx_q, idx_d;
  logic [WORDW-1:0]   mask_q, mask_d, hi_q, hi_d, lo0_q, lo0_d, lo1_q, lo1_d;

  always_comb begin
    idx_d  = sidx_q;
    mask_d = smask_q;
    hi_d   = shi_q;
    lo0_d  = slo0_q;
    lo1_d  = slo1_q;
    unique case (op_q)
      OP_PROBE: idx_d = p_any ? IDXREGW'(p_idx) : PROBE_MISS;
      OP_READ: begin
        if (tgt_ok_q) begin
          mask_d = r_mask;
          hi_d   = r_hi & ~HI_G;
          lo0_d  = r_lo0 | (r_hi[HI_G_BIT] ? LO_G : '0);
          lo1_d  = r_lo1 | (r_hi[HI_G_BIT] ? LO_G : '0);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mask_q <= '0;
      hi_q   <= '0;
      lo0_q  <= '0;
      lo1_q  <= '0;
    end else if (exe_en) begin
      idx_q  <= idx_d;
      mask_q <= mask_d;
      hi_q   <= hi_d;
      lo0_q  <= lo0_d;
      lo1_q  <= lo1_d;
    end
  end

  assign op_busy  = busy_q;
  assign op_done  = done_q;
  assign idx_out  = idx_q;
  assign mask_out = mask_q;
  assign hi_out   = hi_q;
  assign lo0_out  = lo0_q;
  assign lo1_out  = lo1_q;

  // R2: done lasts one cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R2: busy is followed by done and busy drops
  a_r2_busy_to_done: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |=> (done_q && !busy_q));

  // R3: probe result is either the miss code or a legal slot
  a_r3_probe_range: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_q && op_q == OP_PROBE) |-> ((idx_q == PROBE_MISS) || (idx_q < IDXREGW'(NENT))));

  // R5: a good read never reports the flag in the high word, and reports it equally in both lows
  a_r5_read_g_split: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_q && op_q == OP_READ && tgt_ok_q) |-> (!hi_q[HI_G_BIT] && (lo0_q[LO_G_BIT] == lo1_q[LO_G_BIT])));

endmodule

// File: tb/sim_tlbm_unit.sv
module sim_tlbm_unit;
  import tlbm_pkg::*;

  localparam int N = 32;
  localparam logic [31:0] MFLD = 32'h01FF_E000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_go;
  logic [1:0]  op_code;
  logic [63:0] stg_index;
  logic [31:0] stg_mask, stg_hi, stg_lo0, stg_lo1;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        op_busy, op_done;
  logic [63:0] idx_out;
  logic [31:0] mask_out, hi_out, lo0_out, lo1_out;
  logic [4:0]  wired_out, random_out;

  always #2 clk = ~clk;

  tlbm_unit #(.NENT(N), .CNTW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .stg_index(stg_index), .stg_mask(stg_mask), .stg_hi(stg_hi),
    .stg_lo0(stg_lo0), .stg_lo1(stg_lo1), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .op_busy(op_busy), .op_done(op_done), .idx_out(idx_out),
    .mask_out(mask_out), .hi_out(hi_out), .lo0_out(lo0_out), .lo1_out(lo1_out),
    .wired_out(wired_out), .random_out(random_out)
  );

  int errs = 0;
  int total = 0;
  logic [4:0] last_rnd;

  logic [31:0] m_mask [N];
  logic [31:0] m_hi   [N];
  logic [31:0] m_lo0  [N];
  logic [31:0] m_lo1  [N];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [63:0] idx, input logic [31:0] m,
                       input logic [31:0] h, input logic [31:0] l0, input logic [31:0] l1);
    @(negedge clk);
    op_go = 1'b1; op_code = op; stg_index = idx;
    stg_mask = m; stg_hi = h; stg_lo0 = l0; stg_lo1 = l1;
    last_rnd = random_out;
    @(negedge clk);
    op_go = 1'b0;
    @(negedge clk);
    chk("R2 done after op", {63'b0, op_done}, 64'd1);
  endtask

  function automatic void mdl_write(input int i, input logic [31:0] m, input logic [31:0] h,
                                    input logic [31:0] l0, input logic [31:0] l1);
    logic [31:0] sm;
    sm = m & MFLD;
    m_mask[i] = sm;
    m_hi[i]   = (h & ~sm & ~32'h1000) | ((l0[0] & l1[0]) ? 32'h1000 : 32'h0);
    m_lo0[i]  = l0 & ~32'h1;
    m_lo1[i]  = l1 & ~32'h1;
  endfunction

  function automatic logic [63:0] mdl_probe(input logic [31:0] h);
    logic [63:0] r;
    r = 64'hFFFF_FFFF_8000_0000;
    for (int i = 0; i < N; i++)
      if ((m_hi[i][31:13] == h[31:13]) && (m_hi[i][12] || (m_hi[i][7:0] == h[7:0])))
        r = 64'(i);
    return r;
  endfunction

  task automatic rd_check(input int i, input string tag);
    logic g;
    do_op(2'd1, 64'(i), 32'h0, 32'h0, 32'h0, 32'h0);
    g = m_hi[i][12];
    chk({tag, " mask"}, 64'(mask_out), 64'(m_mask[i]));
    chk({tag, " hi"},   64'(hi_out),   64'(m_hi[i] & ~32'h1000));
    chk({tag, " lo0"},  64'(lo0_out),  64'(m_lo0[i] | 32'(g)));
    chk({tag, " lo1"},  64'(lo1_out),  64'(m_lo1[i] | 32'(g)));
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rnd_seq(input logic [4:0] w);
    logic [4:0] s [120];
    bit found;
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      s[t] = random_out;
    end
    found = 1'b0;
    for (int c0 = 0; c0 < 256; c0++) begin
      bit ok;
      ok = 1'b1;
      for (int t = 0; t < 120; t++)
        if (s[t] != 5'(int'(w) + (((c0 + t) % 256) % (N - int'(w))))) ok = 1'b0;
      if (ok) found = 1'b1;
    end
    chk("R10 random follows wired + count mod span", 64'(found), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_go = 1'b0; op_code = 2'd0; stg_index = '0;
    stg_mask = '0; stg_hi = '0; stg_lo0 = '0; stg_lo1 = '0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(op_busy), 64'd0);
    chk("R1 done", 64'(op_done), 64'd0);
    chk("R1 idx", idx_out, 64'd0);
    chk("R1 hi", 64'(hi_out), 64'd0);
    chk("R1 wired", 64'(wired_out), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mask after release", 64'(mask_out), 64'd0);
    chk("R1 lo0 after release", 64'(lo0_out | lo1_out), 64'd0);

    // R6 R7: fill every slot, then read back
    for (int i = 0; i < N; i++) begin
      logic [31:0] m, h, l0, l1;
      m  = (32'(i) * 32'h0001_2345) ^ 32'hFE01_F0F3;
      h  = (32'(i + 1) << 13) | ((i % 2) ? 32'h1000 : 32'h0) | (32'(i % 16) << 8) | 32'((i * 7) % 256);
      l0 = (32'hC0DE_0000 ^ (32'(i) << 4)) | 32'(i % 2);
      l1 = (32'h0BAD_0000 ^ (32'(i) << 8)) | 32'((i / 2) % 2);
      do_op(2'd2, 64'(i), m, h, l0, l1);
      mdl_write(i, m, h, l0, l1);
    end
    for (int i = 0; i < N; i++) rd_check(i, "R5 R6 R7 fill readback");

    // R5: read-by-index passes the index through
    do_op(2'd1, 64'd9, 32'h0, 32'h0, 32'h0, 32'h0);
    chk("R5 read idx passthrough", idx_out, 64'd9);

    // R4: overlapping matches on one page pair
    do_op(2'd2, 64'd3, 32'h0, 32'h8000_0011, 32'h1, 32'h1);   mdl_write(3, 32'h0, 32'h8000_0011, 32'h1, 32'h1);
    do_op(2'd2, 64'd10, 32'h0, 32'h8000_0005, 32'h1, 32'h0);  mdl_write(10, 32'h0, 32'h8000_0005, 32'h1, 32'h0);
    do_op(2'd2, 64'd20, 32'h0, 32'h8000_0007, 32'h0, 32'h1);  mdl_write(20, 32'h0, 32'h8000_0007, 32'h0, 32'h1);
    do_op(2'd0, 64'd0, 32'h0, 32'h8000_0005, 32'h0, 32'h0);
    chk("R4 asid 5 beats lower global", idx_out, 64'd10);
    do_op(2'd0, 64'd0, 32'h0, 32'h8000_0007, 32'h0, 32'h0);
    chk("R4 asid 7 highest match", idx_out, 64'd20);
    do_op(2'd0, 64'd0, 32'h0, 32'h8000_0009, 32'h0, 32'h0);
    chk("R4 only global matches", idx_out, 64'd3);
    do_op(2'd0, 64'd0, 32'h0, 32'hA000_0005, 32'h0, 32'h0);
    chk("R3 probe miss code", idx_out, 64'hFFFF_FFFF_8000_0000);
    rd_check(3, "R5 global entry split");

    // R3 R4: sweep probes over every slot, own and foreign identifiers
    for (int i = 0; i < N; i++) begin
      logic [31:0] h;
      h = m_hi[i] & ~32'h1000;
      do_op(2'd0, 64'd0, 32'h0, h, 32'h0, 32'h0);
      chk("R4 probe sweep own asid", idx_out, mdl_probe(h));
      h = h ^ 32'h0000_00FF;
      do_op(2'd0, 64'd0, 32'h0, h, 32'h0, 32'h0);
      chk("R3 R4 probe sweep foreign asid", idx_out, mdl_probe(h));
    end

    // R8: out-of-range read and write
    do_op(2'd1, 64'd32, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
    chk("R8 oor read mask", 64'(mask_out), 64'h1111_1111);
    chk("R8 oor read hi", 64'(hi_out), 64'h2222_2222);
    chk("R8 oor read lo0", 64'(lo0_out), 64'h3333_3333);
    chk("R8 oor read lo1", 64'(lo1_out), 64'h4444_4444);
    do_op(2'd1, 64'hFFFF_FFFF_8000_0000, 32'h5, 32'h6, 32'h7, 32'h8);
    chk("R8 miss-code read hi", 64'(hi_out), 64'h6);
    do_op(2'd2, 64'd40, 32'h0, 32'hDEAD_BEEF, 32'h1, 32'h1);
    rd_check(8, "R8 oor write leaves slot 8");
    rd_check(0, "R8 oor write leaves slot 0");

    // R2: strobe while busy is ignored
    @(negedge clk);
    op_go = 1'b1; op_code = 2'd1; stg_index = 64'd5;
    @(negedge clk);
    chk("R2 busy after accept", 64'(op_busy), 64'd1);
    op_code = 2'd2; stg_index = 64'd6; stg_hi = 32'hFFFF_FFFF; stg_lo0 = 32'h1; stg_lo1 = 32'h1;
    @(negedge clk);
    op_go = 1'b0;
    chk("R2 first op done", 64'(op_done), 64'd1);
    chk("R2 first op result", 64'(hi_out), 64'(m_hi[5] & ~32'h1000));
    @(negedge clk);
    chk("R2 done is one cycle", 64'(op_done), 64'd0);
    chk("R2 no second busy", 64'(op_busy), 64'd0);
    rd_check(6, "R2 ignored strobe left slot 6");

    // R9: wired masking, random write ignored
    cfg_write(1'b0, 32'hFFFF_FFE7);
    chk("R9 wired masked", 64'(wired_out), 64'd7);
    cfg_write(1'b1, 32'd2);
    chk("R9 random write ignored", 64'(wired_out), 64'd7);
    total++;
    if (random_out < 5'd7) begin
      errs++;
      $display("FAIL R9 random below wired actual=%0d expected>=7", random_out);
    end
    rnd_seq(5'd7);

    // R10: write-random at several wired counts
    for (int k = 0; k < 3; k++) begin
      logic [4:0] w;
      w = (k == 0) ? 5'd0 : ((k == 1) ? 5'd7 : 5'd31);
      cfg_write(1'b0, 32'(w));
      chk("R10 wired set", 64'(wired_out), 64'(w));
      if (k != 1) rnd_seq(w);
      for (int j = 0; j < 3; j++) begin
        logic [31:0] h;
        h = 32'h0100_0000 + 32'(k * 64 + j) * 32'h2000;
        do_op(2'd3, 64'd99, 32'h0, h, 32'h1, 32'h1);
        total++;
        if (last_rnd < w) begin
          errs++;
          $display("FAIL R10 slot below wired actual=%0d expected>=%0d", last_rnd, w);
        end
        mdl_write(int'(last_rnd), 32'h0, h, 32'h1, 32'h1);
        rd_check(int'(last_rnd), "R10 write-random slot");
      end
    end

    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule